// File: doc/BRIEF.md
# Four-Channel Programmable Clock Divider Bank

The block turns one fast source clock into four slower clocks. Each channel has its own divide setting. Software programs the block through two 32-bit registers on a simple write/read bus that runs on the source clock. Each channel owns a 6-bit setting field and a load bit. Writing a setting alone changes nothing. The running divider only takes a new setting after software drives that channel's load bit from 0 to 1. The change then happens at the next period boundary, so the output never shows a shortened pulse.

Channels 1 to 3 use the field value as the divide ratio. Channel 0 instead reads its field as a code, which a fixed, non-monotonic table turns into a ratio. If a setting is invalid when its load edge arrives, it is dropped, and the channel keeps the ratio it already had. A run bit in the second register acts as an active-low reset for all four dividers. While that bit is 0, every output stays low and every channel is held at its idle state.

Top module: `clkdiv_bank`

## Requirements
- R1: Register map. Control register 0 is at byte offset 0 (address bit 2 = 0) and control register 1 is at byte offset 4 (address bit 2 = 1). For channel k, control register 0 holds the 6-bit setting in bits [1+7k +: 6] and the load bit at bit 7+7k. Control register 1 holds the run bit at bit 10. Every bit that has a function reads back the value last written to it. All other bits read 0, so a write of all ones reads back 0x1FFFFFFE at offset 0 and 0x00000400 at offset 4.
- R2: After the synchronous reset `rst`, both registers read 0 and all four outputs are low.
- R3: While the run bit is 0, all outputs are low and load edges are ignored. When the run bit goes to 1, every channel runs at ratio 1 until it is loaded.
- R4: Writing a setting field without a 0-to-1 change of its load bit leaves that channel's ratio unchanged. This includes changing the field while the load bit stays at 1.
- R5: A 0-to-1 change of a channel's load bit, with the run bit at 1, captures that channel's setting field.
- R6: For channels 1 to 3, the ratio equals the field value, 1 to 63. A field value of 0 at the load edge is ignored.
- R7: For channel 0, codes 1 to 10 give ratios 2, 1, 3, 4, 6, 5, 7, 8, 10 and 9. Code 0 and codes 11 to 63 at the load edge are ignored.
- R8: At ratio 1 the output follows the source clock. At ratio N ≥ 2 the output is high for floor(N/2) source cycles and low for ceil(N/2) source cycles in every period.
- R9: A captured ratio takes effect only at the end of the current period. The new period starts low, and no high or low time is shorter than the old or the new ratio dictates.
- R10: Loading one channel leaves the ratios of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; also clocks the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Byte address; bit 2 selects the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| div_clk | output | 4 | Divided clock outputs, one per channel |

## Verification
Channel 1 is swept through all 63 ratios. This separates correct even and odd duty splits and catches off-by-one errors in the period counter. Channel 0 is swept through all ten valid codes and several invalid ones, which exposes any mistake in the permuted table or in the rejection of bad codes. Three further patterns isolate the load condition from the field value:
- a field written with no load edge,
- a field changed while the load bit stays high,
- a load issued while the run bit is 0.

A transition from ratio 63 to ratio 4 is tracked run by run, so a change applied in mid-period would show up as an odd-length pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int NCH    = 4;
    localparam int FW     = 6;
    localparam int DW     = 32;
    localparam int ADDR_W = 3;
    localparam int SEL_BIT  = 2;
    localparam int RUN_BIT  = 10;
    localparam int SLOT_W   = FW + 1;
    localparam int TBL_MAX  = 10;

    typedef logic [FW-1:0] ratio_t;
    typedef logic [DW-1:0] word_t;

    typedef struct packed {
        logic   load;
        ratio_t field;
    } chan_ctl_t;

    function automatic int fld_lsb(input int ch);
        return 1 + ch * SLOT_W;
    endfunction

    function automatic word_t ctrl0_mask();
        word_t m = '0;
        for (int c = 0; c < NCH; c++)
            for (int b = 0; b < SLOT_W; b++)
                m[fld_lsb(c) + b] = 1'b1;
        return m;
    endfunction

    function automatic word_t ctrl1_mask();
        word_t m = '0;
        m[RUN_BIT] = 1'b1;
        return m;
    endfunction

    // Permuted code table of channel 0; 0 marks an invalid code
    function automatic ratio_t code_to_ratio(input ratio_t c);
        case (c)
            6'd1:    return 6'd2;
            6'd2:    return 6'd1;
            6'd3:    return 6'd3;
            6'd4:    return 6'd4;
            6'd5:    return 6'd6;
            6'd6:    return 6'd5;
            6'd7:    return 6'd7;
            6'd8:    return 6'd8;
            6'd9:    return 6'd10;
            6'd10:   return 6'd9;
            default: return 6'd0;
        endcase
    endfunction

    // Number of low cycles in one period of ratio r
    function automatic ratio_t low_len(input ratio_t r);
        logic [FW:0] t;
        t = ({1'b0, r} + 1'b1) >> 1;
        return t[FW-1:0];
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output word_t             rdata,
    output word_t             ctrl0_q,
    output word_t             ctrl1_q
);
    localparam word_t C0M = ctrl0_mask();
    localparam word_t C1M = ctrl1_mask();

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
        end else if (we) begin
            if (addr[SEL_BIT]) ctrl1_q <= wdata & C1M;
            else               ctrl0_q <= wdata & C0M;
        end
    end

    assign rdata = addr[SEL_BIT] ? ctrl1_q : ctrl0_q;

    assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
        (we && !addr[SEL_BIT]) |=> (ctrl0_q == ($past(wdata) & C0M)));
    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (rst)
        ((ctrl1_q & ~C1M) == '0) && ((ctrl0_q & ~C0M) == '0));

endmodule

// File: rtl/clkdiv_chan_ctl.sv
module clkdiv_chan_ctl
    import clkdiv_pkg::*;
#(
    parameter bit USE_TABLE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  chan_ctl_t ctl,
    input  logic      taken,
    output logic      pend_v,
    output ratio_t    pend_r
);
    logic   prev_q;
    logic   rise;
    ratio_t decoded;
    logic   valid;

    generate
        if (USE_TABLE) begin : g_tbl
            assign decoded = code_to_ratio(ctl.field);
        end else begin : g_dir
            assign decoded = ctl.field;
        end
    endgenerate

    assign valid = (decoded != '0);
    assign rise  = ctl.load & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= ctl.load;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pend_v <= 1'b0;
            pend_r <= '0;
        end else if (rise && valid) begin
            pend_v <= 1'b1;
            pend_r <= decoded;
        end else if (taken) begin
            pend_v <= 1'b0;
        end
    end

    assert_bad_code_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (rise && !valid && !pend_v) |=> !pend_v);
    assert_no_load_when_held_R3: assert property (@(posedge clk) disable iff (rst)
        hold |=> !pend_v);

    generate
        if (USE_TABLE) begin : g_tbl_chk
            assert_table_range_R7: assert property (@(posedge clk) disable iff (rst)
                pend_v |-> (pend_r <= ratio_t'(TBL_MAX)));
        end
    endgenerate

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  logic   pend_v,
    input  ratio_t pend_r,
    output logic   taken,
    output logic   clk_out
);
    ratio_t ratio_q, cnt_q;
    ratio_t next_ratio, next_cnt;
    logic   div_q, byp_q, byp_n;
    logic   boundary, div_d;

    assign boundary   = (ratio_q == ratio_t'(1)) || (cnt_q == ratio_q - 1'b1);
    assign taken      = pend_v && boundary && !hold;
    assign next_ratio = taken ? pend_r : ratio_q;
    assign next_cnt   = boundary ? '0 : cnt_q + 1'b1;
    assign div_d      = (next_ratio != ratio_t'(1)) && (next_cnt >= low_len(next_ratio));

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ratio_q <= ratio_t'(1);
            cnt_q   <= '0;
            div_q   <= 1'b0;
            byp_q   <= 1'b0;
        end else begin
            ratio_q <= next_ratio;
            cnt_q   <= next_cnt;
            div_q   <= div_d;
            byp_q   <= (next_ratio == ratio_t'(1));
        end
    end

    // Gate enable re-timed on the falling edge so the pass-through never chops a pulse
    always_ff @(negedge clk) begin
        if (rst) byp_n <= 1'b0;
        else     byp_n <= byp_q;
    end

    assign clk_out = (clk & byp_n) | div_q;

    assert_switch_low_R9: assert property (@(posedge clk) disable iff (rst)
        taken |=> !div_q);
    assert_hold_clears_R3: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!div_q && cnt_q == '0 && ratio_q == ratio_t'(1)));
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio_q);
    assert_ratio_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!taken && !hold) |=> $stable(ratio_q));

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    div_clk
);
    word_t ctrl0_q, ctrl1_q;
    logic  hold;

    clkdiv_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .ctrl0_q (ctrl0_q),
        .ctrl1_q (ctrl1_q)
    );

    assign hold = ~ctrl1_q[RUN_BIT];

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            localparam int LSB = fld_lsb(ch);
            chan_ctl_t ctl;
            logic      pend_v, taken;
            ratio_t    pend_r;

            assign ctl.field = ctrl0_q[LSB +: FW];
            assign ctl.load  = ctrl0_q[LSB + FW];

            clkdiv_chan_ctl #(.USE_TABLE(ch == 0)) u_ctl (
                .clk    (clk),
                .rst    (rst),
                .hold   (hold),
                .ctl    (ctl),
                .taken  (taken),
                .pend_v (pend_v),
                .pend_r (pend_r)
            );

            clkdiv_core u_core (
                .clk     (clk),
                .rst     (rst),
                .hold    (hold),
                .pend_v  (pend_v),
                .pend_r  (pend_r),
                .taken   (taken),
                .clk_out (div_clk[ch])
            );
        end
    endgenerate

    assert_held_low_R3: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold)) |-> (div_clk == '0));

endmodule

// File: tb/tb_clkdiv_bank.sv
`timescale 1ns/1ps
module tb_clkdiv_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  div_clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [31:0] shadow0 = '0;
    int cur [4] = '{1, 1, 1, 1};

    always #5 clk = ~clk;

    clkdiv_bank dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .div_clk   (div_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tbl0(input int code);
        case (code)
            1: return 2;  2: return 1;  3: return 3;  4: return 4;  5: return 6;
            6: return 5;  7: return 7;  8: return 8;  9: return 10; 10: return 9;
            default: return 0;
        endcase
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic set_field(input int ch, input int v, input bit ld);
        shadow0[1 + 7*ch +: 6] = v[5:0];
        shadow0[7 + 7*ch] = ld;
        bus_write(3'd0, shadow0);
    endtask

    task automatic do_load(input int ch, input int v);
        set_field(ch, v, 1'b0);
        set_field(ch, v, 1'b1);
        repeat (25) @(posedge clk);
        set_field(ch, v, 1'b0);
    endtask

    task automatic samp_hi(input int ch, output bit v);
        @(posedge clk); #2 v = div_clk[ch];
    endtask

    task automatic samp_lo(input int ch, output bit v);
        @(negedge clk); #2 v = div_clk[ch];
    endtask

    // Measures one period of channel ch and compares against ratio n
    task automatic measure(input int ch, input int n, input string req);
        bit v, v2;
        int hi = 0, lo = 0, guard = 0;
        if (n == 1) begin
            bit ok = 1'b1;
            for (int i = 0; i < 6; i++) begin
                samp_hi(ch, v); samp_lo(ch, v2);
                if (!v || v2) ok = 1'b0;
            end
            chk(ok, req, ok ? 1 : 0, 1);
            return;
        end
        samp_hi(ch, v);
        while (v && guard < 300) begin samp_hi(ch, v); guard++; end
        while (!v && guard < 300) begin samp_hi(ch, v); guard++; end
        while (v && guard < 300) begin hi++; samp_hi(ch, v); guard++; end
        while (!v && guard < 300) begin lo++; samp_hi(ch, v); guard++; end
        chk(hi == n/2, req, hi, n/2);
        chk(lo == n - n/2, req, lo, n - n/2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit v, v2, ok;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R2: reset state
        bus_read(3'd0, rd); chk(rd == 0, "R2 ctrl0", rd, 0);
        bus_read(3'd4, rd); chk(rd == 0, "R2 ctrl1", rd, 0);
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            samp_hi(0, v); samp_lo(0, v2);
            if (div_clk != 0 || v || v2) ok = 1'b0;
        end
        chk(ok, "R2 outputs low", div_clk, 0);

        // R1: readback while held
        bus_write(3'd0, 32'hFFFF_FFFF);
        bus_read(3'd0, rd); chk(rd == 32'h1FFF_FFFE, "R1 ctrl0 mask", rd, 32'h1FFF_FFFE);
        shadow0 = '0;
        bus_write(3'd0, shadow0);

        // R3: load while run bit 0 is ignored, outputs low
        do_load(1, 5);
        repeat (20) @(posedge clk);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            samp_hi(1, v); samp_lo(1, v2);
            if (div_clk != 0) ok = 1'b0;
        end
        chk(ok, "R3 held low", div_clk, 0);
        bus_write(3'd4, 32'hFFFF_FFFF);
        bus_read(3'd4, rd); chk(rd == 32'h0000_0400, "R1 ctrl1 mask", rd, 32'h400);
        repeat (10) @(posedge clk);
        for (int ch = 0; ch < 4; ch++) measure(ch, 1, "R3 release ratio 1");

        // R7 + R5: channel 0 code sweep
        for (int c = 1; c <= 10; c++) begin
            do_load(0, c);
            cur[0] = tbl0(c);
            repeat (140) @(posedge clk);
            measure(0, cur[0], "R7 code table");
        end
        foreach (cur[i]) if (i == 0) begin
            int bad [4] = '{0, 11, 40, 63};
            for (int k = 0; k < 4; k++) begin
                do_load(0, bad[k]);
                repeat (140) @(posedge clk);
                measure(0, cur[0], "R7 invalid code ignored");
            end
        end

        // R6 + R8: channel 1 full ratio sweep
        for (int r = 1; r <= 63; r++) begin
            do_load(1, r);
            cur[1] = r;
            repeat (140) @(posedge clk);
            measure(1, r, "R8 ratio sweep");
        end
        do_load(1, 0);
        repeat (140) @(posedge clk);
        measure(1, cur[1], "R6 zero ignored");

        // R4: field write without load edge
        set_field(2, 7, 1'b0);
        repeat (140) @(posedge clk);
        measure(2, 1, "R4 no load edge");
        set_field(2, 7, 1'b1);
        cur[2] = 7;
        repeat (140) @(posedge clk);
        measure(2, 7, "R5 load edge");
        set_field(2, 12, 1'b1);
        repeat (140) @(posedge clk);
        measure(2, 7, "R4 load held high");
        set_field(2, 12, 1'b0);

        // R9: boundary switch 63 -> 4, track run lengths
        do_load(3, 63);
        repeat (140) @(posedge clk);
        begin
            int run = 0, nruns = 0;
            bit prev, first = 1'b1, good = 1'b1;
            int badlen = 0;
            set_field(3, 4, 1'b0);
            set_field(3, 4, 1'b1);
            samp_hi(3, prev);
            for (int i = 0; i < 300; i++) begin
                samp_hi(3, v);
                if (v == prev) run++;
                else begin
                    if (!first) begin
                        nruns++;
                        if (prev && !(run + 1 == 31 || run + 1 == 2)) begin good = 1'b0; badlen = run + 1; end
                        if (!prev && !(run + 1 == 32 || run + 1 == 2)) begin good = 1'b0; badlen = run + 1; end
                    end
                    first = 1'b0;
                    run = 0;
                    prev = v;
                end
            end
            chk(good, "R9 no runt at switch", badlen, 0);
            chk(nruns > 10, "R9 switch happened", nruns, 11);
            set_field(3, 4, 1'b0);
            cur[3] = 4;
        end
        measure(3, 4, "R9 new ratio");

        // R10: channels independent
        for (int ch = 0; ch < 4; ch++) measure(ch, cur[ch], "R10 other channels kept");

        // R3: drop run bit, then release
        bus_write(3'd4, 32'h0);
        repeat (3) @(posedge clk);
        ok = 1'b1;
        for (int i = 0; i < 70; i++) begin
            samp_hi(0, v); samp_lo(0, v2);
            if (div_clk != 0) ok = 1'b0;
        end
        chk(ok, "R3 run bit low", div_clk, 0);
        bus_write(3'd4, 32'h400);
        repeat (10) @(posedge clk);
        for (int ch = 0; ch < 4; ch++) measure(ch, 1, "R3 restart ratio 1");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule